// File: doc/BRIEF.md
# Receive FIFO with RTS Hysteresis

This block holds received serial bytes until the host reads them. It sits between the byte strobe of a serial receiver and a host read port. The bytes are kept in a circular store, with a write pointer, a read pointer and an occupancy count that are all held separately. The block also drives the request-to-send line, which holds off the remote sender. The line drops when the store fills to half its depth and rises again only when the store drains to a quarter of its depth. The gap between the two marks keeps the line from toggling on every byte near one threshold.

A configurable trap byte is not stored. When it arrives, it raises a one-cycle reboot request. A flush input returns the store to its empty state. A byte that arrives while the store is full is dropped without any indication.

Top module: `rxq_flow_buf`

## Requirements
- R1: After reset the count is 0, `data_avail` is 0, `rts` is 1, `rd_valid` is 0 and `reboot_req` is 0.
- R2: A byte strobed with `wr_valid`, when not full, not the trap byte and not flushed, raises the count by one. Bytes come out in arrival order, including across pointer wrap. A read is requested with `rd_req` while the count is non-zero. The byte is presented on `rd_data` with `rd_valid` high on the clock after the request, and the count falls by one.
- R3: A byte arriving while the count equals DEPTH is discarded. The count and the stored contents do not change.
- R4: An accepted write without a read that brings the count to exactly DEPTH/2 drives `rts` to 0.
- R5: A read without a write that brings the count to exactly DEPTH/4 drives `rts` to 1. At any other count `rts` keeps its value, so it stays 0 while the count moves between the two marks.
- R6: An accepted write and a valid read in the same cycle leave the count unchanged and advance both pointers.
- R7: A read while the count is 0 is ignored: `rd_valid` stays 0 and `rd_data` keeps its previous value.
- R8: `flush` sets the count to 0, empties the store and sets `rts` to 1 on the next clock. It overrides a write or a read in the same cycle.
- R9: `data_avail` is 1 exactly when the count is non-zero.
- R10: When TRAP_EN is 1, a strobed byte equal to TRAP_BYTE is not stored, and `reboot_req` is 1 for one cycle on the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Byte strobe from the receiver |
| wr_data | input | DATA_W | Received byte |
| rd_req | input | 1 | Host read request |
| rd_data | output | DATA_W | Byte returned to host |
| rd_valid | output | 1 | rd_data updated this cycle |
| flush | input | 1 | Empty the store and re-enable the sender |
| count | output | $clog2(DEPTH+1) | Occupancy |
| data_avail | output | 1 | Count non-zero |
| rts | output | 1 | Request-to-send, 1 allows the sender |
| reboot_req | output | 1 | One-cycle pulse on trap byte |

## Verification
The bench builds the block with DEPTH=8, so the drop mark is 4 and the rise mark is 2. At this depth a few dozen cycles reach full, overflow, pointer wrap and every step of the hysteresis band. It also sets TRAP_BYTE=8'hA5. A byte-wide pseudo-random stream therefore hits the trap value now and then, including while the store is full or being flushed. A directed pass fills, overflows and drains the store, and a long random pass then compares every output after every clock against an arithmetic queue model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_PUSH = 2'd1,
        EV_POP  = 2'd2,
        EV_BOTH = 2'd3
    } rxq_ev_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = mem_q[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rxq_rts.sv
module rxq_rts
    import rxq_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int HI_MARK = 16,
    parameter int LO_MARK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  rxq_ev_e          ev,
    input  logic [CNT_W-1:0] cnt_next,
    output logic             rts
);
    logic rts_d, rts_q;

    always_comb begin
        rts_d = rts_q;
        if (flush)
            rts_d = 1'b1;
        else if (ev == EV_PUSH && cnt_next == CNT_W'(HI_MARK))
            rts_d = 1'b0;
        else if (ev == EV_POP && cnt_next == CNT_W'(LO_MARK))
            rts_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rts_q <= 1'b1;
        else        rts_q <= rts_d;
    end

    assign rts = rts_q;
endmodule

// File: rtl/rxq_trap.sv
module rxq_trap #(
    parameter int              DATA_W    = 8,
    parameter bit              TRAP_EN   = 1'b1,
    parameter logic [DATA_W-1:0] TRAP_BYTE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hit,
    output logic              pulse
);
    logic pulse_d, pulse_q;

    generate
        if (TRAP_EN) begin : g_trap
            assign hit = wr_valid && (wr_data == TRAP_BYTE);
        end else begin : g_notrap
            assign hit = 1'b0;
        end
    endgenerate

    always_comb pulse_d = hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
    end

    assign pulse = pulse_q;

    // R10: a reboot pulse follows only a strobed trap byte
    a_r10_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (TRAP_EN && $past(wr_valid) && $past(wr_data) == TRAP_BYTE));
endmodule

// File: rtl/rxq_flow_buf.sv
module rxq_flow_buf
    import rxq_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                DEPTH     = 32,
    parameter bit                TRAP_EN   = 1'b1,
    parameter logic [DATA_W-1:0] TRAP_BYTE = 8'hA5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_req,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_valid,
    input  logic                       flush,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       data_avail,
    output logic                       rts,
    output logic                       reboot_req
);
    localparam int PTR_W   = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int HI_MARK = DEPTH / 2;
    localparam int LO_MARK = DEPTH / 4;

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic             rd_vld;
    } ctl_t;

    ctl_t    ctl_d, ctl_q;
    logic    trap_hit, push, pop;
    rxq_ev_e ev;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    rxq_trap #(.DATA_W(DATA_W), .TRAP_EN(TRAP_EN), .TRAP_BYTE(TRAP_BYTE)) u_trap (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .hit(trap_hit), .pulse(reboot_req)
    );

    always_comb begin
        push  = wr_valid && !trap_hit && !flush && (ctl_q.cnt != CNT_W'(DEPTH));
        pop   = rd_req && !flush && (ctl_q.cnt != '0);
        ev    = rxq_ev_e'({pop, push});
        ctl_d = ctl_q;
        ctl_d.rd_vld = pop;
        if (flush) begin
            ctl_d.wptr = '0;
            ctl_d.rptr = '0;
            ctl_d.cnt  = '0;
        end else begin
            if (push) ctl_d.wptr = bump(ctl_q.wptr);
            if (pop)  ctl_d.rptr = bump(ctl_q.rptr);
            case (ev)
                EV_PUSH: ctl_d.cnt = ctl_q.cnt + 1'b1;
                EV_POP:  ctl_d.cnt = ctl_q.cnt - 1'b1;
                default: ctl_d.cnt = ctl_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(push), .waddr(ctl_q.wptr), .wdata(wr_data),
        .re(pop), .raddr(ctl_q.rptr), .rdata(rd_data)
    );

    rxq_rts #(.CNT_W(CNT_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_rts (
        .clk(clk), .rst_n(rst_n), .flush(flush), .ev(ev),
        .cnt_next(ctl_d.cnt), .rts(rts)
    );

    assign count      = ctl_q.cnt;
    assign data_avail = (ctl_q.cnt != '0);
    assign rd_valid   = ctl_q.rd_vld;

    // R2: occupancy never exceeds the depth
    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= CNT_W'(DEPTH));
    // R3: write pointer frozen while full
    a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.cnt == CNT_W'(DEPTH) && !flush) |=> $stable(ctl_q.wptr));
    // R4: rts only falls at the half mark
    a_r4_rts_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts) |-> ctl_q.cnt == CNT_W'(HI_MARK));
    // R5: rts only rises at the quarter mark or after a flush
    a_r5_rts_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts) |-> (ctl_q.cnt == CNT_W'(LO_MARK) || ctl_q.cnt == '0));
    // R6: concurrent write and read keep the count
    a_r6_both_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !trap_hit && rd_req && !flush && ctl_q.cnt != '0
         && ctl_q.cnt != CNT_W'(DEPTH)) |=> $stable(ctl_q.cnt));
    // R7: empty read gives no valid strobe
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && ctl_q.cnt == '0) |=> !rd_valid);
    // R8: flush empties and re-enables the sender
    a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ctl_q.cnt == '0 && rts));
endmodule

// File: tb/tb_rxq_flow_buf.sv
module tb_rxq_flow_buf;
    localparam int   DEPTH = 8;
    localparam int   HI    = DEPTH / 2;
    localparam int   LO    = DEPTH / 4;
    localparam logic [7:0] TRAP = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, rd_req = 1'b0, flush = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_valid, data_avail, rts, reboot_req;
    logic [3:0] count;

    int checks = 0, fails = 0;
    logic [7:0] mq[$];
    int   m_cnt = 0;
    logic m_rts = 1'b1, m_vld = 1'b0, m_reboot = 1'b0;
    logic [7:0] m_last = '0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    rxq_flow_buf #(.DATA_W(8), .DEPTH(DEPTH), .TRAP_EN(1'b1), .TRAP_BYTE(TRAP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .flush(flush),
        .count(count), .data_avail(data_avail), .rts(rts), .reboot_req(reboot_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic wv, input logic [7:0] wd, input logic rr, input logic fl);
        logic hit, acc, rok;
        wr_valid = wv; wr_data = wd; rd_req = rr; flush = fl;
        hit = wv && (wd == TRAP);
        rok = rr && !fl && (m_cnt != 0);
        acc = wv && !hit && !fl && (m_cnt != DEPTH);
        m_reboot = hit;
        m_vld = rok;
        if (fl) begin
            mq.delete(); m_cnt = 0; m_rts = 1'b1;
        end else begin
            if (rok) begin m_last = mq.pop_front(); m_cnt--; end
            if (acc) begin mq.push_back(wd); m_cnt++; end
            if (acc && !rok && m_cnt == HI) m_rts = 1'b0;
            if (rok && !acc && m_cnt == LO) m_rts = 1'b1;
        end
        @(posedge clk);
        #1;
        wr_valid = 1'b0; rd_req = 1'b0; flush = 1'b0;
        chk("R2 R3 R6 R8 count", int'(count), m_cnt);
        chk("R9 data_avail", int'(data_avail), int'(m_cnt != 0));
        chk("R4 R5 rts", int'(rts), int'(m_rts));
        chk("R2 R7 rd_valid", int'(rd_valid), int'(m_vld));
        chk("R2 R7 rd_data", int'(rd_data), int'(m_last));
        chk("R10 reboot_req", int'(reboot_req), int'(m_reboot));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 data_avail", int'(data_avail), 0);
        chk("R1 rts", int'(rts), 1);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 reboot_req", int'(reboot_req), 0);
        // R7 empty reads
        step(0, 0, 1, 0); step(0, 0, 1, 0);
        // R3 R4 fill past full
        for (int i = 0; i < DEPTH + 3; i++) step(1, 8'(i + 1), 0, 0);
        // R10 trap byte while full
        step(1, TRAP, 0, 0);
        // R5 drain and over-read
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, 0);
        // R6 concurrent traffic with wrap
        step(1, 8'h40, 0, 0);
        for (int i = 0; i < 3 * DEPTH; i++) step(1, 8'(8'h50 + i), 1, 0);
        // R5 hysteresis band bounce
        for (int i = 0; i < HI; i++) step(1, 8'(8'h70 + i), 0, 0);
        step(0, 0, 1, 0); step(1, 8'h7F, 0, 0); step(0, 0, 1, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0);
        // R8 flush with concurrent write then reuse
        for (int i = 0; i < HI + 1; i++) step(1, 8'(8'h90 + i), 0, 0);
        step(1, 8'h33, 1, 1);
        chk("R8 flushed count", int'(count), 0);
        chk("R8 flushed rts", int'(rts), 1);
        step(1, 8'h44, 0, 0); step(0, 0, 1, 0);
        chk("R8 first byte after flush", int'(rd_data), 8'h44);
        // random sweep
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[3], lf[15:8] ^ lf[7:0], lf[1] | (lf[4] & lf[6]),
                 lf[5:0] == 6'h2A);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule